// File: doc/BRIEF.md
# Performance Monitor Counter Bank

This block holds ten 48-bit event counters that watch a processor core. Counter 0 advances on every clock while it is enabled. Counter 1 advances on each retired-instruction pulse. Each of counters 2 to 9 has an 8-bit selector that picks one line of a 256-wide per-cycle event-pulse vector. A counter advances only when three things hold: its count enable is set, the enable for the current privilege level (user or kernel) is set, and counting is not frozen.

Software reaches everything through a simple synchronous register port. A write takes effect at the clock edge where `reg_wr` is high, and reads are combinational from `reg_addr`. Two control words set the count enables, the interrupt enables, the interrupt mode, the stop-on-interrupt flag and the privilege filters. A status word keeps one sticky overflow flag per counter. A flag is raised when an increment sets bit 47, which is the top bit of the counter.

Interrupt delivery is a two-state machine. `ST_IDLE` moves to `ST_ACTIVE` when an interrupt output is raised, or when software writes the active flag as 1. `ST_ACTIVE` returns to `ST_IDLE` only when software writes control word 0 with the active flag at 0. The active flag read back in control word 0 is this state.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset, every counter, control word, selector and status flag reads 0, and `pmi_irq`, `fiq_irq` and `halt_req` are low.
- R2: Counter 0 adds one on every clock edge at which it is allowed to count. Counter 1 adds one on every edge at which it is allowed and `retire_pulse` is high. Writes to the selector words never change either source.
- R3: Counters 2 to 5 take their selectors from selector word 0, and counters 6 to 9 from selector word 1. Counter 2+k uses bits 8k+7:8k of word 0, and counter 6+k uses the same bits of word 1. Each of these counters adds one per edge at which `evt_pulse[selector]` is high and counting is allowed.
- R4: In control word 0, bits 7:0 are the count enables for counters 0 to 7, and bits 33:32 are those for counters 8 and 9. A counter whose enable is clear keeps its value.
- R5: In control word 1, bits 15:8 (counters 0 to 7) and bits 41:40 (counters 8 and 9) allow counting when `priv_kernel` is 0. Bits 23:16 and bits 49:48 allow counting when `priv_kernel` is 1.
- R6: A software write to a counter takes priority over an increment in the same cycle.
- R7: The overflow flag of a counter is set at the edge where an increment changes bit 47 from 0 to 1. A wrap from all ones to zero sets no flag, and the counter keeps counting.
- R8: Status bits 9:0 are sticky. A write to the status word replaces them, but an overflow in the same cycle still sets its flag.
- R9: Control word 0 holds the interrupt enables in bits 19:12 (counters 0 to 7) and bits 45:44 (counters 8 and 9), and the mode in bits 10:8. While any flagged counter has its interrupt enable set, mode 1 drives `pmi_irq`, mode 3 drives `halt_req` and mode 4 drives `fiq_irq`. Mode 0 and every other mode drive no output.
- R10: Bit 11 of control word 0 is the active flag. It becomes 1 one edge after an interrupt output rises and holds until software writes it as 0.
- R11: While bit 20 of control word 0 and the active flag are both 1, no counter increments.
- R12: Register addresses are: counters 0 to 9 at 0 to 9, control word 0 at 10, control word 1 at 11, selector words at 12 and 13, and status at 14. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr` |
| evt_pulse | input | 256 | Per-cycle event pulses |
| retire_pulse | input | 1 | Instruction retired this cycle |
| priv_kernel | input | 1 | 1 = kernel level, 0 = user level |
| pmi_irq | output | 1 | Interrupt in mode 1 |
| fiq_irq | output | 1 | Interrupt in mode 4 |
| halt_req | output | 1 | Halt request in mode 3 |

## Verification
The hardest case to reach is the overflow itself. Setting bit 47 by counting would take about 2^47 events. The stimulus therefore preloads a counter through the register port to one or two below the threshold, and also to all ones to exercise the wrap. From there, single event pulses take the counter across the threshold. That flagged state is then the starting point for the interrupt-mode sweep, the freeze while the interrupt is active, and a status write that collides with a fresh overflow in the same cycle.

// File: rtl/pmon_pkg.sv
`timescale 1ns/1ps
package pmon_pkg;
    localparam int NUM_CNT     = 10;
    localparam int LOW_GRP     = 8;
    localparam int HI_GRP      = NUM_CNT - LOW_GRP;
    localparam int FIRST_SEL   = 2;
    localparam int SEL_PER_REG = 4;
    localparam int REG_W       = 64;
    localparam int ADDR_W      = 4;

    localparam logic [ADDR_W-1:0] A_CTRL0 = 4'd10;
    localparam logic [ADDR_W-1:0] A_CTRL1 = 4'd11;
    localparam logic [ADDR_W-1:0] A_SEL0  = 4'd12;
    localparam logic [ADDR_W-1:0] A_SEL1  = 4'd13;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'd14;

    // control word 0 field positions
    localparam int C0_CEN_LO = 0;
    localparam int C0_MODE   = 8;
    localparam int C0_IACT   = 11;
    localparam int C0_IEN_LO = 12;
    localparam int C0_STOP   = 20;
    localparam int C0_CEN_HI = 32;
    localparam int C0_IEN_HI = 44;
    // control word 1 field positions
    localparam int C1_UEN_LO = 8;
    localparam int C1_KEN_LO = 16;
    localparam int C1_UEN_HI = 40;
    localparam int C1_KEN_HI = 48;

    localparam logic [2:0] MODE_OFF  = 3'd0;
    localparam logic [2:0] MODE_PMI  = 3'd1;
    localparam logic [2:0] MODE_HALT = 3'd3;
    localparam logic [2:0] MODE_FIQ  = 3'd4;

    typedef enum logic {ST_IDLE, ST_ACTIVE} irq_state_e;
endpackage

// File: rtl/pmon_slot.sv
`timescale 1ns/1ps
module pmon_slot #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse,
    input  logic             allow,
    input  logic             wr_hit,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_set
);
    localparam int OVF_BIT = CNT_W - 1;

    logic bump;
    assign bump    = pulse & allow & ~wr_hit;
    assign ovf_set = bump & ~cnt[OVF_BIT] & (&cnt[OVF_BIT-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (wr_hit) cnt <= wr_val;
        else if (bump)   cnt <= cnt + 1'b1;
    end

    assert_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> cnt == $past(wr_val));
    assert_ovf_msb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> (cnt[OVF_BIT] && cnt[OVF_BIT-1:0] == '0));
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!allow && !wr_hit) |=> $stable(cnt));
endmodule

// File: rtl/pmon_irq_ctl.sv
`timescale 1ns/1ps
module pmon_irq_ctl
    import pmon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pend,
    input  logic [2:0] mode,
    input  logic       sw_wr,
    input  logic       sw_iact,
    output logic       iact,
    output logic       pmi_o,
    output logic       fiq_o,
    output logic       halt_o
);
    irq_state_e state_q, state_d;
    logic raise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (raise || (sw_wr && sw_iact)) state_d = ST_ACTIVE;
            ST_ACTIVE: if (sw_wr && !sw_iact)           state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pmi_o  = 1'b0;
        fiq_o  = 1'b0;
        halt_o = 1'b0;
        unique case (mode)
            MODE_PMI:  pmi_o  = pend;
            MODE_HALT: halt_o = pend;
            MODE_FIQ:  fiq_o  = pend;
            default:   ;
        endcase
        iact = (state_q == ST_ACTIVE);
    end

    assign raise = pmi_o | fiq_o | halt_o;

    assert_one_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pmi_o, fiq_o, halt_o}));
    assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |-> !(pmi_o || fiq_o || halt_o));
    assert_iact_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (raise && !sw_wr) |=> iact);
    assert_iact_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (iact && !sw_wr) |=> iact);
endmodule

// File: rtl/perf_counter_bank.sv
`timescale 1ns/1ps
module perf_counter_bank
    import pmon_pkg::*;
#(
    parameter int CNT_W = 48,
    parameter int EVT_W = 8,
    localparam int NUM_EVT = 1 << EVT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic              retire_pulse,
    input  logic              priv_kernel,
    output logic              pmi_irq,
    output logic              fiq_irq,
    output logic              halt_req
);
    logic [NUM_CNT-1:0] cen_q, ien_q, uen_q, ken_q, stat_q;
    logic [NUM_CNT-1:0] ovf_vec, wr_hit, allow, pulse_v;
    logic [2:0]         mode_q;
    logic               stop_q, iact, freeze, pend;
    logic [CNT_W-1:0]   cnt_v  [NUM_CNT];
    logic [EVT_W-1:0]   sel_rd [NUM_CNT];

    logic wr_c0, wr_c1, wr_st;
    assign wr_c0  = reg_wr && (reg_addr == A_CTRL0);
    assign wr_c1  = reg_wr && (reg_addr == A_CTRL1);
    assign wr_st  = reg_wr && (reg_addr == A_STAT);
    assign freeze = stop_q & iact;
    assign pend   = |(stat_q & ien_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cen_q  <= '0;
            ien_q  <= '0;
            mode_q <= MODE_OFF;
            stop_q <= 1'b0;
            uen_q  <= '0;
            ken_q  <= '0;
            stat_q <= '0;
        end else begin
            if (wr_c0) begin
                cen_q  <= {reg_wdata[C0_CEN_HI +: HI_GRP], reg_wdata[C0_CEN_LO +: LOW_GRP]};
                ien_q  <= {reg_wdata[C0_IEN_HI +: HI_GRP], reg_wdata[C0_IEN_LO +: LOW_GRP]};
                mode_q <= reg_wdata[C0_MODE +: 3];
                stop_q <= reg_wdata[C0_STOP];
            end
            if (wr_c1) begin
                uen_q <= {reg_wdata[C1_UEN_HI +: HI_GRP], reg_wdata[C1_UEN_LO +: LOW_GRP]};
                ken_q <= {reg_wdata[C1_KEN_HI +: HI_GRP], reg_wdata[C1_KEN_LO +: LOW_GRP]};
            end
            stat_q <= (wr_st ? reg_wdata[NUM_CNT-1:0] : stat_q) | ovf_vec;
        end
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        if (i == 0) begin : g_cyc
            assign pulse_v[i] = 1'b1;
            assign sel_rd[i]  = '0;
        end else if (i == 1) begin : g_ret
            assign pulse_v[i] = retire_pulse;
            assign sel_rd[i]  = '0;
        end else begin : g_sel
            localparam int BANK = (i - FIRST_SEL) / SEL_PER_REG;
            localparam int LANE = (i - FIRST_SEL) % SEL_PER_REG;
            localparam logic [ADDR_W-1:0] SEL_ADDR = (BANK == 0) ? A_SEL0 : A_SEL1;
            logic [EVT_W-1:0] sel_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                               sel_q <= '0;
                else if (reg_wr && reg_addr == SEL_ADDR)  sel_q <= reg_wdata[LANE*EVT_W +: EVT_W];
            end
            assign pulse_v[i] = evt_pulse[sel_q];
            assign sel_rd[i]  = sel_q;
        end

        assign wr_hit[i] = reg_wr && (reg_addr == ADDR_W'(i));
        assign allow[i]  = cen_q[i] & (priv_kernel ? ken_q[i] : uen_q[i]) & ~freeze;

        pmon_slot #(.CNT_W(CNT_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .pulse   (pulse_v[i]),
            .allow   (allow[i]),
            .wr_hit  (wr_hit[i]),
            .wr_val  (reg_wdata[CNT_W-1:0]),
            .cnt     (cnt_v[i]),
            .ovf_set (ovf_vec[i])
        );
    end

    pmon_irq_ctl u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    (pend),
        .mode    (mode_q),
        .sw_wr   (wr_c0),
        .sw_iact (reg_wdata[C0_IACT]),
        .iact    (iact),
        .pmi_o   (pmi_irq),
        .fiq_o   (fiq_irq),
        .halt_o  (halt_req)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL0: begin
                reg_rdata[C0_CEN_LO +: LOW_GRP] = cen_q[LOW_GRP-1:0];
                reg_rdata[C0_CEN_HI +: HI_GRP]  = cen_q[NUM_CNT-1:LOW_GRP];
                reg_rdata[C0_IEN_LO +: LOW_GRP] = ien_q[LOW_GRP-1:0];
                reg_rdata[C0_IEN_HI +: HI_GRP]  = ien_q[NUM_CNT-1:LOW_GRP];
                reg_rdata[C0_MODE +: 3]         = mode_q;
                reg_rdata[C0_IACT]              = iact;
                reg_rdata[C0_STOP]              = stop_q;
            end
            A_CTRL1: begin
                reg_rdata[C1_UEN_LO +: LOW_GRP] = uen_q[LOW_GRP-1:0];
                reg_rdata[C1_UEN_HI +: HI_GRP]  = uen_q[NUM_CNT-1:LOW_GRP];
                reg_rdata[C1_KEN_LO +: LOW_GRP] = ken_q[LOW_GRP-1:0];
                reg_rdata[C1_KEN_HI +: HI_GRP]  = ken_q[NUM_CNT-1:LOW_GRP];
            end
            A_SEL0: for (int k = 0; k < SEL_PER_REG; k++)
                reg_rdata[k*EVT_W +: EVT_W] = sel_rd[FIRST_SEL + k];
            A_SEL1: for (int k = 0; k < SEL_PER_REG; k++)
                reg_rdata[k*EVT_W +: EVT_W] = sel_rd[FIRST_SEL + SEL_PER_REG + k];
            A_STAT: reg_rdata[NUM_CNT-1:0] = stat_q;
            default: for (int k = 0; k < NUM_CNT; k++)
                if (reg_addr == ADDR_W'(k)) reg_rdata[CNT_W-1:0] = cnt_v[k];
        endcase
    end

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_st |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
    assert_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !reg_wr) |=> $stable(cnt_v[0]));
endmodule

// File: tb/sim_perf_counter_bank.sv
`timescale 1ns/1ps
module sim_perf_counter_bank;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   reg_addr = '0;
    logic         reg_wr = 1'b0;
    logic [63:0]  reg_wdata = '0;
    logic [63:0]  reg_rdata;
    logic [255:0] evt_pulse = '0;
    logic         retire_pulse = 1'b0;
    logic         priv_kernel = 1'b0;
    logic         pmi_irq, fiq_irq, halt_req;

    always #2 clk = ~clk;   // 250 MHz

    perf_counter_bank u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
        .retire_pulse(retire_pulse), .priv_kernel(priv_kernel),
        .pmi_irq(pmi_irq), .fiq_irq(fiq_irq), .halt_req(halt_req)
    );

    typedef struct {
        int          kind;   // 0: read data, 1: {halt,fiq,pmi}
        logic [63:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // monitor: compares queued expectations with what the design shows
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [63:0] act;
            it  = q.pop_front();
            act = (it.kind == 1) ? {61'b0, halt_req, fiq_irq, pmi_irq} : reg_rdata;
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
            end
        end
    end

    task automatic chk(int kind, logic [3:0] a, logic [63:0] e, string tag);
        item_t it;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = a;
        it.kind = kind; it.exp = e; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [63:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic wrp(logic [3:0] a, logic [63:0] d, int idx);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; evt_pulse[idx] = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0; evt_pulse[idx] = 1'b0;
    endtask

    // idx 256 selects the retire input
    task automatic pulse(int idx, int n);
        @(posedge clk); #1;
        if (idx < 256) evt_pulse[idx] = 1'b1; else retire_pulse = 1'b1;
        repeat (n) @(posedge clk);
        #1;
        evt_pulse = '0; retire_pulse = 1'b0;
    endtask

    localparam logic [63:0] UALL = (64'hFF << 8)  | (64'h3 << 40);
    localparam logic [63:0] KALL = (64'hFF << 16) | (64'h3 << 48);
    localparam logic [63:0] EN   = 64'hFC | (64'h3 << 32);
    localparam logic [63:0] IE3  = 64'h1 << 15;
    localparam logic [63:0] IACT = 64'h1 << 11;
    localparam logic [63:0] STOP = 64'h1 << 20;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        for (int a = 0; a < 16; a++) chk(0, 4'(a), 64'h0, "R1/R12 reset value");
        chk(1, 0, 64'h0, "R1 irq lines after reset");

        // cycle and retire counters
        wr(4'd11, UALL | KALL);
        wr(4'd10, 64'h1);
        repeat (5) @(posedge clk);
        wr(4'd10, 64'h0);
        chk(0, 4'd0, 64'd7, "R2 cycle counter");
        wr(4'd10, 64'h2);
        pulse(256, 3);
        wr(4'd12, 64'h1234_5678);
        wr(4'd13, 64'h9ABC_DEF0);
        pulse(256, 2);
        wr(4'd10, 64'h0);
        chk(0, 4'd1, 64'd5, "R2 retire counter ignores selector writes");
        chk(0, 4'd0, 64'd7, "R4 disabled cycle counter holds");

        // selected events
        wr(4'd12, 64'h4030_2A11);
        wr(4'd13, 64'hFE77_6655);
        wr(4'd10, EN);
        pulse(8'h11, 3);
        pulse(8'h2A, 2);
        pulse(8'hFE, 4);
        pulse(8'h77, 1);
        pulse(8'h99, 2);
        chk(0, 4'd2, 64'd3, "R3 counter 2 byte0 of word0");
        chk(0, 4'd3, 64'd2, "R3 counter 3 byte1 of word0");
        chk(0, 4'd9, 64'd4, "R3 counter 9 byte3 of word1");
        chk(0, 4'd8, 64'd1, "R3 counter 8 byte2 of word1");
        chk(0, 4'd4, 64'd0, "R3 unselected event");
        chk(0, 4'd12, 64'h4030_2A11, "R12 selector word0 readback");
        chk(0, 4'd13, 64'hFE77_6655, "R12 selector word1 readback");

        // high-group enable
        wr(4'd10, 64'hFC | (64'h1 << 32));
        pulse(8'hFE, 2);
        pulse(8'h77, 1);
        chk(0, 4'd9, 64'd4, "R4 counter 9 disabled by bit33");
        chk(0, 4'd8, 64'd2, "R4 counter 8 enabled by bit32");
        chk(0, 4'd10, 64'hFC | (64'h1 << 32), "R12 control word 0 readback");

        // privilege filter
        wr(4'd10, EN);
        wr(4'd11, (64'h1 << 10) | (64'h1 << 49));
        priv_kernel = 1'b1;
        pulse(8'h11, 2);
        pulse(8'hFE, 2);
        priv_kernel = 1'b0;
        pulse(8'h11, 1);
        pulse(8'hFE, 1);
        chk(0, 4'd2, 64'd4, "R5 counter 2 user only");
        chk(0, 4'd9, 64'd6, "R5 counter 9 kernel only");
        chk(0, 4'd11, (64'h1 << 10) | (64'h1 << 49), "R12 control word 1 readback");

        // write beats increment
        wrp(4'd2, 64'h10, 8'h11);
        chk(0, 4'd2, 64'h10, "R6 write wins over event");
        pulse(8'h11, 1);
        chk(0, 4'd2, 64'h11, "R6 counting resumes");

        // overflow at bit 47
        wr(4'd11, (64'h1 << 10) | (64'h1 << 11) | (64'h1 << 12) | (64'h1 << 13) | (64'h1 << 49));
        wr(4'd3, 64'h7FFF_FFFF_FFFE);
        pulse(8'h2A, 1);
        chk(0, 4'd3, 64'h7FFF_FFFF_FFFF, "R7 below threshold");
        chk(0, 4'd14, 64'h0, "R7 no flag below threshold");
        pulse(8'h2A, 1);
        chk(0, 4'd3, 64'h8000_0000_0000, "R7 bit47 reached");
        chk(0, 4'd14, 64'h8, "R7 flag for counter 3");
        wr(4'd4, 64'hFFFF_FFFF_FFFF);
        pulse(8'h30, 1);
        chk(0, 4'd4, 64'h0, "R7 wrap to zero");
        chk(0, 4'd14, 64'h8, "R7 wrap sets no flag");
        chk(1, 0, 64'h0, "R9 no interrupt enable");

        // interrupt modes
        wr(4'd10, EN | IE3 | (64'd1 << 8));
        chk(1, 0, 64'b001, "R9 mode 1 pmi");
        chk(0, 4'd10, EN | IE3 | (64'd1 << 8) | IACT, "R10 active flag set");
        wr(4'd10, EN | IE3 | (64'd4 << 8) | IACT);
        chk(1, 0, 64'b010, "R9 mode 4 fiq");
        wr(4'd10, EN | IE3 | (64'd3 << 8) | IACT);
        chk(1, 0, 64'b100, "R9 mode 3 halt");
        wr(4'd10, EN | IE3 | (64'd2 << 8) | IACT);
        chk(1, 0, 64'b000, "R9 mode 2 silent");
        wr(4'd10, EN | IE3 | IACT);
        chk(1, 0, 64'b000, "R9 mode off silent");

        // freeze while active
        wr(4'd10, EN | IE3 | (64'd1 << 8) | IACT | STOP);
        pulse(8'h11, 2);
        chk(0, 4'd2, 64'h11, "R11 frozen while active");
        wr(4'd10, EN | IE3 | (64'd1 << 8) | IACT);
        pulse(8'h11, 1);
        chk(0, 4'd2, 64'h12, "R11 counts without stop bit");

        // sticky status and active flag
        chk(0, 4'd14, 64'h8, "R8 flag sticky");
        wr(4'd14, 64'h0);
        chk(0, 4'd14, 64'h0, "R8 status cleared by write");
        chk(1, 0, 64'h0, "R9 irq drops with flag");
        chk(0, 4'd10, EN | IE3 | (64'd1 << 8) | IACT, "R10 active flag holds");
        wr(4'd10, EN | IE3 | (64'd1 << 8));
        chk(0, 4'd10, EN | IE3 | (64'd1 << 8), "R10 active flag cleared");
        wr(4'd5, 64'h7FFF_FFFF_FFFF);
        wrp(4'd14, 64'h0, 8'h40);
        chk(0, 4'd14, 64'h20, "R8 new overflow beats status write");
        chk(0, 4'd5, 64'h8000_0000_0000, "R7 counter 5 reached bit47");
        chk(1, 0, 64'h0, "R9 flag without enable");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule